// File: doc/BRIEF.md
# Periodic Interrupt and Call-Delay Counter

This block holds a counter, eight bits wide by default, that moves forward by one on each 10 ms tick strobe. Software sets a modulus through a single register index, which is 05H. Every time the counter reaches that modulus, the block pulses an interrupt, returns the counter to zero and keeps counting. Writing to the shared index loads the modulus, and reading from it returns the current count.

A zero modulus turns the interrupt off at once. The counter then keeps climbing until it hits its all-ones value, which is 255 ticks (2.55 s), and stops there. A call-detected strobe clears the modulus and the count together. After that, the counter climbs from zero, so a later read tells software how many hundredths of a second have passed since the call. The tail saturates at 255 and stays there until software writes a non-zero modulus.

Top module: `periodic_irq_counter`

## Requirements
- R1: After reset, irq is low, the modulus is zero and the count reads as all ones (255), which is the halted state.
- R2: With a non-zero modulus M and a count c for which c+1 is not M, a tick with no write and no call in the same cycle sets the count to c+1.
- R3: With a non-zero modulus M, a tick that would bring the count to M instead returns the count to zero and drives irq high for exactly the following clock cycle. irq is never high at any other time.
- R4: A write of non-zero data loads the data as the modulus and clears the count to zero.
- R5: A write of zero clears the modulus and the count. From then on irq stays low, and ticks advance the count up to 255.
- R6: When call_det is high, the modulus and the count both clear to zero, and a later read gives the number of ticks since then. If wr_en is high in the same cycle, call_det takes priority.
- R7: When rd_en is high, rd_data shows the count; when rd_en is low, rd_data is zero. A read has no effect on the state.
- R8: A tick in the same cycle as a write or a call is discarded; that cycle's write or clear alone decides the new count.
- R9: Once the modulus is zero and the count is 255, ticks leave the count unchanged, and a write of zero has no effect. Only a write of non-zero data or a call restarts the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe every 10 ms |
| wr_en | input | 1 | Write strobe for index 05H, which loads the modulus |
| wr_data | input | WIDTH | Modulus value to load |
| rd_en | input | 1 | Read enable for index 05H |
| call_det | input | 1 | Call-detected strobe |
| irq | output | 1 | One-cycle interrupt pulse |
| rd_data | output | WIDTH | Count when rd_en is high, otherwise zero |

## Verification
The bench builds the block with its default WIDTH of 8, so the full 255-tick tail, the saturation at 255 and the halted state after it are all covered. It drives the tick strobe on most clock cycles rather than once every 10 ms. Because of that, the whole tail and many wrap periods of small moduli fit inside a short run, and random writes, calls and ticks can collide often enough to test the priority rules.

// File: rtl/periodic_irq_counter.sv
module periodic_irq_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             call_det,
  output logic             irq,
  output logic [WIDTH-1:0] rd_data
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] mod_q, cnt_q;
  logic             irq_q;

  wire             mod_on  = (mod_q != '0);
  wire             halted  = !mod_on && (cnt_q == TOP);
  wire [WIDTH-1:0] cnt_inc = cnt_q + ONE;
  wire             wrap    = mod_on && (cnt_inc == mod_q);
  wire             load    = wr_en && ((wr_data != '0) || !halted);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_q <= '0;
      cnt_q <= TOP;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (call_det) begin
        mod_q <= '0;
        cnt_q <= '0;
      end else if (wr_en) begin
        if (load) begin
          mod_q <= wr_data;
          cnt_q <= '0;
        end
      end else if (tick) begin
        if (wrap) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else if (!halted) begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  assign irq     = irq_q;
  assign rd_data = rd_en ? cnt_q : '0;

  assert_irq_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));

  assert_no_irq_zero_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q == '0) |=> !irq);

  assert_cnt_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != '0) |-> (cnt_q < mod_q));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && !call_det && (mod_q != '0) && (cnt_q + ONE != mod_q))
      |=> (cnt_q == $past(cnt_q) + ONE));

  assert_call_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_det |=> (cnt_q == '0 && mod_q == '0));

  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mod_q == '0) && (cnt_q == TOP) && !call_det && !(wr_en && wr_data != '0))
      |=> $stable(cnt_q));

  assert_rd_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: tb/sim_periodic_irq_counter.sv
module sim_periodic_irq_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0, call_det = 1'b0;
  logic [7:0] wr_data = '0;
  logic       irq;
  logic [7:0] rd_data;

  int total = 0, failed = 0;
  int m_mod = 0, m_cnt = 255;
  bit done = 0;

  always #4 clk = ~clk;

  periodic_irq_counter #(.WIDTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .call_det(call_det), .irq(irq), .rd_data(rd_data)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model_step(bit t, bit w, int d, bit c);
    bit fire = 0;
    if (c) begin
      m_mod = 0; m_cnt = 0;
    end else if (w) begin
      if (d != 0 || !(m_mod == 0 && m_cnt == 255)) begin
        m_mod = d; m_cnt = 0;
      end
    end else if (t) begin
      if (m_mod != 0) begin
        if (m_cnt + 1 == m_mod) begin m_cnt = 0; fire = 1; end
        else m_cnt = m_cnt + 1;
      end else if (m_cnt != 255) m_cnt = m_cnt + 1;
    end
    return fire;
  endfunction

  task automatic step(bit t, bit w, int d, bit r, bit c, string tag);
    bit exp_irq;
    tick = t; wr_en = w; wr_data = d[7:0]; rd_en = r; call_det = c;
    exp_irq = model_step(t, w, d, c);
    @(posedge clk); @(negedge clk);
    chk(irq == exp_irq, "R3 irq", int'(irq), int'(exp_irq));
    chk(rd_data == (r ? m_cnt[7:0] : 8'd0), tag, int'(rd_data), r ? m_cnt : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 0, "R1 reset count");
    repeat (5) step(1, 0, 0, 1, 0, "R1 halted after reset");
    step(0, 1, 3, 1, 0, "R4 nonzero write");
    repeat (7) step(1, 0, 0, 1, 0, "R2 increment");
    step(1, 1, 5, 1, 0, "R8 tick with write");
    step(1, 0, 0, 1, 0, "R2 after load");
    step(1, 1, 0, 1, 0, "R5 zero write");
    repeat (300) step(1, 0, 0, 1, 0, "R5 tail");
    step(0, 0, 0, 1, 0, "R9 saturated");
    step(1, 1, 0, 1, 0, "R9 zero write when halted");
    repeat (3) step(1, 0, 0, 1, 0, "R9 still halted");
    step(0, 1, 4, 1, 0, "R4 restart");
    repeat (2) step(1, 0, 0, 1, 0, "R2 run");
    step(1, 1, 7, 1, 1, "R6 call beats write");
    repeat (10) step(1, 0, 0, 1, 0, "R6 delay count");
    step(1, 0, 0, 0, 0, "R7 rd gated");
    step(0, 0, 0, 1, 0, "R7 read after gated");
    step(0, 1, 1, 1, 0, "R4 modulus one");
    repeat (4) step(1, 0, 0, 1, 0, "R3 every tick");
    for (int i = 0; i < 4000; i++) begin
      bit t, w, r, c;
      int d, sel;
      t = ($urandom % 100) < 70;
      w = ($urandom % 100) < 3;
      c = ($urandom % 100) < 1;
      r = ($urandom % 100) < 80;
      sel = $urandom % 4;
      d = (sel == 0) ? 0 : (sel == 1) ? int'($urandom % 256) : int'(1 + $urandom % 8);
      step(t, w, d, r, c, "R2 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule